// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of a bidirectional parallel port running in extended-capability mode, handling the peripheral-to-host direction. When a read is requested it reverses the bus and accepts byte transfers from the peripheral. The Busy level seen at each transfer decides whether the byte on the data lines is data or a command. Commands are either run counts or channel addresses. The block places the resulting bytes on a valid/ready output stream, and a run count makes the following data byte come out several times.

A read is started with a one-cycle `start` pulse, and `byte_limit` sets how many stream bytes the read may produce. The read ends with a one-cycle `done` pulse. `timeout` is raised in the same cycle when the peripheral misses a response window. Repeats still owed when the limit is reached are kept and come out first on the next read. A `fwd_req` pulse returns the bus to the host-to-peripheral direction. Repeats come from a down-counter and a single held byte, not from a buffer. The stream stalls for as long as the consumer holds `out_ready` low.

Top module: `ecp_rev_rx`

## Requirements
- R1: Reset state. `dir_in_o`=0, `n_autofd_o`=1, `n_init_o`=1, `n_strobe_o`=1, `n_selectin_o`=1, `out_valid`=0, `done`=0, `timeout`=0.
- R2: Reversal on `start` while `dir_in_o`=0:
  - In the next cycle, `dir_in_o` goes to 1 and `n_autofd_o` goes to 0.
  - `n_init_o` goes to 0 SETUP_CYC+1 cycles after the start edge.
  - `n_strobe_o` and `n_selectin_o` stay 1.
  - The block then waits for `perror_i` low. If `perror_i` does not go low within RESP_CYC cycles, the read ends with `done` and `timeout`.
  - Stream bytes appear only while `dir_in_o`=1 and `n_init_o`=0.
- R3: A transfer starts when the synchronized `n_ack_i` is low. If no transfer starts within IDLE_CYC cycles, the read ends early with `done` and with `timeout`=0.
- R4: A transfer with `busy_i`=1 is a data byte. The value on `pd_i` appears once on `out_data`.
- R5: A transfer with `busy_i`=0 and `pd_i[7]`=1 is a channel address. It is discarded and produces no stream byte.
- R6: A transfer with `busy_i`=0 and `pd_i[7]`=0 sets a run count N=`pd_i[6:0]`. The next data byte appears N+1 times in a row.
- R7: Handshake for each transfer:
  - Once the byte is taken (accepted on the stream, or at once for a command), `n_autofd_o` goes to 1.
  - The block waits for `n_ack_i` high, then drives `n_autofd_o` to 0.
  - If `n_ack_i` stays low for RESP_CYC cycles, the read ends with `done` and `timeout`.
  - `n_autofd_o` is 0 whenever `out_valid` is 1.
- R8: A read ends with `done` after exactly `byte_limit` stream bytes. Repeats still owed are output first on the next read, with no transfer needed. A `byte_limit` of 0 gives `done` at once, with no output and no pin change.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold.
- R10: Return to forward:
  - A `fwd_req` pulse while idle with `dir_in_o`=1 drives `n_init_o` to 1 and waits for `perror_i` high.
  - Then `n_autofd_o` goes to 1, `dir_in_o` goes to 0 and `done` pulses.
  - If `perror_i` is not high within RESP_CYC cycles, the same release happens with `timeout`.
- R11: `done` and `timeout` are one-cycle pulses, and `timeout` is only ever 1 together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: begin a read |
| fwd_req | input | 1 | Pulse: return the bus to the forward direction |
| byte_limit | input | CNT_W | Maximum stream bytes for this read, sampled with `start` |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Consumer ready |
| done | output | 1 | Pulse: read or return finished |
| timeout | output | 1 | Pulse with `done`: a response window expired |
| n_ack_i | input | 1 | Peripheral transfer strobe, active low |
| busy_i | input | 1 | Data/command flag from the peripheral |
| perror_i | input | 1 | Peripheral bus-turn acknowledge |
| pd_i | input | 8 | Parallel data lines |
| n_autofd_o | output | 1 | Host acknowledge line |
| n_init_o | output | 1 | Reverse-request line |
| n_strobe_o | output | 1 | Strobe line, held high |
| n_selectin_o | output | 1 | Select line, held high |
| dir_in_o | output | 1 | Data-line direction, 1 = input |

## Verification
The assertions assume that `start` and `fwd_req` arrive only while the block is idle. They also assume that the peripheral does not start a new transfer before the host has dropped its acknowledge, and that `pd_i` and `busy_i` are settled before `n_ack_i` falls. The bench peripheral model waits for `n_autofd_o` low before it presents a byte, drives the data and Busy lines one step ahead of `n_ack_i`, and follows `n_init_o` with `perror_i` after a fixed delay that fits inside RESP_CYC. Requests are issued only after the previous `done` has been seen.

// File: rtl/ecprx_pkg.sv
package ecprx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TURN_SETUP,
    ST_TURN_WAIT,
    ST_NEXT,
    ST_WAIT_XFER,
    ST_EMIT,
    ST_REPEAT,
    ST_ACK_WAIT,
    ST_FWD_WAIT
  } rx_state_e;

  typedef enum logic [1:0] {
    TM_SETUP,
    TM_RESP,
    TM_IDLE
  } tmr_sel_e;
endpackage

// File: rtl/ecprx_sync.sv
module ecprx_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else if (i == 0) stage_q[i] <= d;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ecprx_timer.sv
module ecprx_timer
  import ecprx_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int RESP_CYC  = 16,
  parameter int IDLE_CYC  = 2000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tmr_sel_e sel,
  output logic     expired
);
  localparam int MAX_AB = (SETUP_CYC > RESP_CYC) ? SETUP_CYC : RESP_CYC;
  localparam int MAXC   = (MAX_AB > IDLE_CYC) ? MAX_AB : IDLE_CYC;
  localparam int TMR_W  = $clog2(MAXC + 1);

  logic [TMR_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    case (sel)
      TM_SETUP: load_val = TMR_W'(SETUP_CYC);
      TM_RESP:  load_val = TMR_W'(RESP_CYC);
      default:  load_val = TMR_W'(IDLE_CYC);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecprx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SETUP_CYC   = 4,
  parameter int RESP_CYC    = 16,
  parameter int IDLE_CYC    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fwd_req,
  input  logic [CNT_W-1:0] byte_limit,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             timeout,
  input  logic             n_ack_i,
  input  logic             busy_i,
  input  logic             perror_i,
  input  logic [7:0]       pd_i,
  output logic             n_autofd_o,
  output logic             n_init_o,
  output logic             n_strobe_o,
  output logic             n_selectin_o,
  output logic             dir_in_o
);
  localparam int RUN_W = 7;

  rx_state_e        state_q, state_d;
  logic             afd_q, afd_d, init_q, init_d, dir_q, dir_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [RUN_W-1:0] rep_cnt_q, rep_cnt_d, run_len_q, run_len_d;
  logic [7:0]       rep_byte_q, rep_byte_d;
  logic             run_flag_q, run_flag_d;
  logic             done_q, done_d, tout_q, tout_d;
  logic             tmr_load, tmr_exp;
  tmr_sel_e         tmr_sel;
  logic             ack_s, busy_s, perr_s;

  ecprx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({n_ack_i, busy_i, perror_i}),
    .q    ({ack_s, busy_s, perr_s})
  );

  ecprx_timer #(.SETUP_CYC(SETUP_CYC), .RESP_CYC(RESP_CYC), .IDLE_CYC(IDLE_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .sel    (tmr_sel),
    .expired(tmr_exp)
  );

  always_comb begin
    state_d    = state_q;
    afd_d      = afd_q;
    init_d     = init_q;
    dir_d      = dir_q;
    remain_d   = remain_q;
    rep_cnt_d  = rep_cnt_q;
    run_len_d  = run_len_q;
    rep_byte_d = rep_byte_q;
    run_flag_d = run_flag_q;
    done_d     = 1'b0;
    tout_d     = 1'b0;
    tmr_load   = 1'b0;
    tmr_sel    = TM_RESP;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          remain_d = byte_limit;
          if (byte_limit == '0) begin
            done_d = 1'b1;
          end else if (!dir_q) begin
            state_d  = ST_TURN_SETUP;
            dir_d    = 1'b1;
            afd_d    = 1'b0;
            tmr_load = 1'b1;
            tmr_sel  = TM_SETUP;
          end else begin
            state_d = ST_NEXT;
          end
        end else if (fwd_req && dir_q) begin
          state_d  = ST_FWD_WAIT;
          init_d   = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_TURN_SETUP: begin
        if (tmr_exp) begin
          state_d  = ST_TURN_WAIT;
          init_d   = 1'b0;
          tmr_load = 1'b1;
        end
      end
      ST_TURN_WAIT: begin
        if (!perr_s) begin
          state_d = ST_NEXT;
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          tout_d  = 1'b1;
        end
      end
      ST_NEXT: begin
        if (remain_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          afd_d = 1'b0;
          if (rep_cnt_q != '0) begin
            state_d = ST_REPEAT;
          end else begin
            state_d  = ST_WAIT_XFER;
            tmr_load = 1'b1;
            tmr_sel  = TM_IDLE;
          end
        end
      end
      ST_WAIT_XFER: begin
        if (!ack_s) begin
          if (busy_s) begin
            rep_byte_d = pd_i;
            state_d    = ST_EMIT;
            if (run_flag_q) begin
              rep_cnt_d  = run_len_q;
              run_flag_d = 1'b0;
            end
          end else begin
            if (!pd_i[7]) begin
              run_len_d  = pd_i[RUN_W-1:0];
              run_flag_d = 1'b1;
            end
            state_d  = ST_ACK_WAIT;
            afd_d    = 1'b1;
            tmr_load = 1'b1;
          end
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          remain_d = remain_q - 1'b1;
          state_d  = ST_ACK_WAIT;
          afd_d    = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_REPEAT: begin
        if (out_ready) begin
          remain_d  = remain_q - 1'b1;
          rep_cnt_d = rep_cnt_q - 1'b1;
          state_d   = ST_NEXT;
        end
      end
      ST_ACK_WAIT: begin
        if (ack_s) begin
          state_d = ST_NEXT;
          afd_d   = 1'b0;
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          tout_d  = 1'b1;
        end
      end
      ST_FWD_WAIT: begin
        if (perr_s || tmr_exp) begin
          state_d = ST_IDLE;
          afd_d   = 1'b1;
          dir_d   = 1'b0;
          done_d  = 1'b1;
          tout_d  = !perr_s;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      afd_q      <= 1'b1;
      init_q     <= 1'b1;
      dir_q      <= 1'b0;
      remain_q   <= '0;
      rep_cnt_q  <= '0;
      run_len_q  <= '0;
      rep_byte_q <= '0;
      run_flag_q <= 1'b0;
      done_q     <= 1'b0;
      tout_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      afd_q      <= afd_d;
      init_q     <= init_d;
      dir_q      <= dir_d;
      remain_q   <= remain_d;
      rep_cnt_q  <= rep_cnt_d;
      run_len_q  <= run_len_d;
      rep_byte_q <= rep_byte_d;
      run_flag_q <= run_flag_d;
      done_q     <= done_d;
      tout_q     <= tout_d;
    end
  end

  assign out_valid    = (state_q == ST_EMIT) || (state_q == ST_REPEAT);
  assign out_data     = rep_byte_q;
  assign done         = done_q;
  assign timeout      = tout_q;
  assign n_autofd_o   = afd_q;
  assign n_init_o     = init_q;
  assign n_strobe_o   = 1'b1;
  assign n_selectin_o = 1'b1;
  assign dir_in_o     = dir_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done,
  input logic       timeout,
  input logic       dir_in_o,
  input logic       n_init_o,
  input logic       n_autofd_o
);
  // R9: a stalled byte is held
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2: stream bytes only while the bus is reversed
  p_out_reversed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dir_in_o && !n_init_o);

  // R7: host acknowledge stays low while a byte is offered
  p_out_afd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !n_autofd_o);

  // R11: timeout only together with done
  p_tout_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  // R2: entering reverse lowers acknowledge before the reverse request
  p_rev_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_in_o) |-> !n_autofd_o && n_init_o);

  // R10: leaving reverse releases both lines
  p_fwd_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_in_o) |-> n_autofd_o && n_init_o && done);
endmodule

bind ecp_rev_rx ecp_rev_rx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .timeout   (timeout),
  .dir_in_o  (dir_in_o),
  .n_init_o  (n_init_o),
  .n_autofd_o(n_autofd_o)
);

// File: tb/ecp_rev_rx_tb_top.sv
module ecp_rev_rx_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, fwd_req = 1'b0;
  logic [CNT_W-1:0] byte_limit = '0;
  logic [7:0] out_data;
  logic out_valid, out_ready = 1'b1;
  logic done, timeout;
  logic n_ack = 1'b1, busy = 1'b0, perror = 1'b1;
  logic [7:0] pd = 8'h00;
  logic n_autofd_o, n_init_o, n_strobe_o, n_selectin_o, dir_in_o;

  always #10 clk = ~clk;

  ecp_rev_rx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fwd_req(fwd_req),
    .byte_limit(byte_limit), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .timeout(timeout),
    .n_ack_i(n_ack), .busy_i(busy), .perror_i(perror), .pd_i(pd),
    .n_autofd_o(n_autofd_o), .n_init_o(n_init_o), .n_strobe_o(n_strobe_o),
    .n_selectin_o(n_selectin_o), .dir_in_o(dir_in_o)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [8:0] xfer_q[$];
  int run_pend = -1;
  logic stuck = 1'b0, rnd_ready = 1'b0;
  int got = 0;
  logic done_seen = 1'b0, tout_seen = 1'b0, prev_done = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: queue a transfer and predict its stream bytes
  task automatic send(input logic is_data, input logic [7:0] b);
    xfer_q.push_back({is_data, b});
    if (is_data) begin
      int n = (run_pend >= 0) ? run_pend + 1 : 1;
      for (int i = 0; i < n; i++) exp_q.push_back(b);
      run_pend = -1;
    end else if (!b[7]) begin
      run_pend = int'(b[6:0]);
    end
  endtask

  // peripheral model
  initial begin
    forever begin
      logic [8:0] x;
      while (xfer_q.size() == 0) @(posedge clk);
      wait (dir_in_o == 1'b1 && n_autofd_o == 1'b0);
      #30;
      x = xfer_q.pop_front();
      pd = x[7:0];
      busy = x[8];
      #30 n_ack = 1'b0;
      wait (n_autofd_o == 1'b1 && !stuck);
      #30 n_ack = 1'b1;
    end
  end

  always @(n_init_o) begin
    #100;
    perror = n_init_o;
  end

  always @(posedge clk) begin
    #1;
    out_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        got++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", int'(out_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R4/R6 stream byte", int'(out_data), int'(e));
        end
      end
      if (timeout && !done) chk(1'b0, "R11 timeout without done", 1, 0);
      if (done && prev_done) chk(1'b0, "R11 done wider than one cycle", 2, 1);
      if (done) begin
        done_seen = 1'b1;
        tout_seen = timeout;
      end
      prev_done = done;
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_seen && n < 20000) begin
      @(posedge clk);
      n++;
    end
    chk(done_seen, req, 0, 1);
    @(posedge clk);
    #2;
  endtask

  task automatic do_read(input int lim, input logic chk_turn);
    done_seen = 1'b0;
    tout_seen = 1'b0;
    got = 0;
    @(posedge clk);
    #1;
    byte_limit = CNT_W'(lim);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    if (chk_turn) begin
      chk(dir_in_o && !n_autofd_o && n_init_o, "R2 reversal first step",
          int'({dir_in_o, n_autofd_o, n_init_o}), 3'b101);
      chk(n_strobe_o && n_selectin_o, "R2 strobe/select high",
          int'({n_strobe_o, n_selectin_o}), 2'b11);
    end
    wait_done("R8 read ends with done");
  endtask

  initial begin
    #10000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #55;
    // R1 reset state
    chk(!dir_in_o && n_autofd_o && n_init_o && n_strobe_o && n_selectin_o,
        "R1 pins at reset",
        int'({dir_in_o, n_autofd_o, n_init_o, n_strobe_o, n_selectin_o}), 5'b01111);
    chk(!out_valid && !done && !timeout, "R1 outputs at reset",
        int'({out_valid, done, timeout}), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8 zero limit
    do_read(0, 1'b0);
    chk(got == 0 && !dir_in_o, "R8 zero limit no output, no reversal", got, 0);

    // R2 + R4 plain data
    send(1'b1, 8'h11); send(1'b1, 8'h22); send(1'b1, 8'h33); send(1'b1, 8'h44);
    do_read(4, 1'b1);
    chk(!n_init_o && dir_in_o, "R2 reversed after read", int'({dir_in_o, n_init_o}), 2'b10);
    chk(got == 4 && !tout_seen, "R4 four data bytes", got, 4);

    // R5 channel address dropped
    send(1'b0, 8'h85); send(1'b1, 8'h5A);
    do_read(1, 1'b0);
    chk(got == 1, "R5 address produced no byte", got, 1);
    chk(xfer_q.size() == 0, "R5 both transfers consumed", xfer_q.size(), 0);

    // R6 + R9 run expansion with stalls
    rnd_ready = 1'b1;
    send(1'b0, 8'h03); send(1'b1, 8'hA5); send(1'b1, 8'h77);
    do_read(5, 1'b0);
    chk(got == 5, "R6 run of four plus one, R9 under stalls", got, 5);
    rnd_ready = 1'b0;

    // R8 limit reached mid-run, owed repeats next read
    send(1'b0, 8'h05); send(1'b1, 8'h3C);
    do_read(3, 1'b0);
    chk(got == 3, "R8 first part of run", got, 3);
    do_read(3, 1'b0);
    chk(got == 3 && !tout_seen, "R8 owed repeats without transfer", got, 3);
    send(1'b1, 8'h99);
    do_read(1, 1'b0);
    chk(got == 1, "R8 fresh byte after owed run", got, 1);

    // R3 idle limit ends read early
    do_read(2, 1'b0);
    chk(got == 0 && !tout_seen, "R3 idle end without timeout", got, 0);

    // R7 response timeout
    stuck = 1'b1;
    send(1'b1, 8'hE1);
    do_read(2, 1'b0);
    chk(tout_seen, "R7 handshake timeout flagged", int'(tout_seen), 1);
    chk(got == 1 && n_autofd_o, "R7 byte out, acknowledge left high", got, 1);
    stuck = 1'b0;
    repeat (10) @(posedge clk);

    // R10 return to forward
    done_seen = 1'b0;
    tout_seen = 1'b0;
    @(posedge clk);
    #1 fwd_req = 1'b1;
    @(posedge clk);
    #1 fwd_req = 1'b0;
    wait_done("R10 forward done");
    chk(!dir_in_o && n_autofd_o && n_init_o && !tout_seen, "R10 bus forward",
        int'({dir_in_o, n_autofd_o, n_init_o, tout_seen}), 4'b0110);

    chk(exp_q.size() == 0, "R6 all predicted bytes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule